// File: doc/BRIEF.md
# Bus Target with Four-Way Strap Address

This block is the two-wire serial target interface of a small configuration device. It runs entirely on a fast system clock. The incoming clock and data lines and the address strap pin pass through a two-flop synchronizer. The block then recognises start, repeated start and stop conditions from edges of the synchronized lines. After a start, it takes the first byte as a 7-bit address plus a direction bit. In write direction it acknowledges every byte. In read direction it shifts out register bytes and watches the controller's acknowledge after each one.

The low two bits of the address come from a single strap pin. Board designers may wire that pin to ground, to the supply, to the clock line or to the data line. During the address byte the block compares the strap pin with the bus lines and decides which of the four wirings is present. It then matches the received address against the one that wiring implies. A 16-byte register array with an auto-incrementing pointer stands behind the interface. The block drives the data line only through an active-low pull-down enable.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset the pull-down enable `sda_oe_n` is 1 (line released), the register pointer is 0, and all 16 registers read as 0x00.
- R2: A start is the data line falling while the clock line is high. The address byte that follows is taken most significant bit first, one bit per clock-high period.
- R3: The strap decides the low two address bits: ground gives code 0, supply code 1, clock line code 2, data line code 3. The 7-bit address is `{5'b10011, code}`, so the write bytes are 0x98, 0x9A, 0x9C and 0x9E and the read bytes are these plus one.
- R4: When the address matches, the block pulls the data line low (`sda_oe_n` = 0) through the whole ninth clock-high period.
- R5: On an address mismatch the line stays released in the ninth clock. Every following byte is neither acknowledged nor driven until the next start.
- R6: In write direction the first data byte loads the pointer from its low four bits. Each later byte is written to the register at the pointer, and the pointer then increments and wraps from 15 to 0. Every write byte is acknowledged.
- R7: In read direction the block returns the register at the pointer, most significant bit first, and increments the pointer after each byte. A low level in the ninth clock (acknowledge) makes it continue with the next byte.
- R8: A high level in the ninth clock of a read byte (not-acknowledge) makes the block release the line and ignore the bus until the next start or stop.
- R9: A stop (data line rising while the clock line is high) at any bit position returns the block to idle. A byte clocked afterwards without a new start is not acknowledged, and a partly received byte changes no register.
- R10: A stop in the same clock-high period as the preceding start is ignored, and the address byte that follows is still recognised.
- R11: A repeated start restarts address reception without passing through idle, and the register pointer keeps its value across it.
- R12: `sda_oe_n` falls only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Address strap pin, wired to ground, supply, clock or data line |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line (0 = drive low) |

## Verification
The hardest cases to reach from the ports are the strap wired to a bus line and the stop that lands inside the start's own clock-high period. The bench handles the strap by routing the strap input through a selector fed from its own clock line and the resolved wired-AND data line. The strap therefore follows the bus exactly as a board trace would. For the second case, a directed sequence raises the data line again before the clock falls after a start, then sends an address without a new start and expects an acknowledge. Random transactions mix all four strap wirings, wrong addresses, pointer wrap and repeated starts.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BITCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WR   = 3'd2,
    ST_RD   = 3'd3,
    ST_WAIT = 3'd4
  } tgt_state_e;

  typedef enum logic [1:0] {
    STRAP_GND = 2'd0,
    STRAP_VDD = 2'd1,
    STRAP_SCL = 2'd2,
    STRAP_SDA = 2'd3
  } strap_e;

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_prev_q;
  logic sda_prev_q;
  logic scl_hi_both;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  // clock held high across the sample pair: data edges are conditions
  assign scl_hi_both = scl_s & scl_prev_q;
  assign scl_rise    = scl_s & ~scl_prev_q;
  assign scl_fall    = ~scl_s & scl_prev_q;
  assign start_ev    = scl_hi_both & sda_prev_q & ~sda_s;
  assign stop_ev     = scl_hi_both & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_strap_classify.sv
module i2c_strap_classify
  import i2c_strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   sample,
  input  logic   strap_s,
  input  logic   scl_s,
  input  logic   sda_s,
  output strap_e code
);

  logic all_low_q, all_high_q, follow_scl_q, follow_sda_q;
  logic all_low_d, all_high_d, follow_scl_d, follow_sda_d;

  always_comb begin
    all_low_d    = all_low_q;
    all_high_d   = all_high_q;
    follow_scl_d = follow_scl_q;
    follow_sda_d = follow_sda_q;
    if (clear) begin
      all_low_d    = 1'b1;
      all_high_d   = 1'b1;
      follow_scl_d = 1'b1;
      follow_sda_d = 1'b1;
    end else if (sample) begin
      all_low_d    = all_low_q    & ~strap_s;
      all_high_d   = all_high_q   &  strap_s;
      follow_scl_d = follow_scl_q & (strap_s == scl_s);
      follow_sda_d = follow_sda_q & (strap_s == sda_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_low_q    <= 1'b1;
      all_high_q   <= 1'b1;
      follow_scl_q <= 1'b1;
      follow_sda_q <= 1'b1;
    end else begin
      all_low_q    <= all_low_d;
      all_high_q   <= all_high_d;
      follow_scl_q <= follow_scl_d;
      follow_sda_q <= follow_sda_d;
    end
  end

  // fixed priority: constant levels first, then clock line, else data line
  always_comb begin
    if (all_low_q)         code = STRAP_GND;
    else if (all_high_q)   code = STRAP_VDD;
    else if (follow_scl_q) code = STRAP_SCL;
    else                   code = STRAP_SDA;
  end

endmodule

// File: rtl/i2c_strap_regs.sv
module i2c_strap_regs #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic          wr_en,
  input  logic          rd_adv,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DEPTH-1:0] wr_sel;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
      assign wr_sel[g] = wr_en && (ptr_q == AW'(g));
    end
  endgenerate

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld)               ptr_d = wr_data[AW-1:0];
    else if (wr_en || rd_adv) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_sel[i]) mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[ptr_q];

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_strap_pkg::*;
#(
  parameter logic [4:0]  ADDR_UPPER = 5'b10011,
  parameter int unsigned REG_DEPTH  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic sda_oe_n
);

  localparam logic [BITCNT_W-1:0] BIT_LAST = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] BIT_ACK  = BITCNT_W'(BYTE_W + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // synchronized pad inputs
  logic [2:0] sync_q;
  logic scl_s, sda_s, strap_s;

  i2c_sync2 #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     ({strap_i, sda_i, scl_i}),
    .q     (sync_q)
  );
  assign scl_s   = sync_q[0];
  assign sda_s   = sync_q[1];
  assign strap_s = sync_q[2];

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // state
  tgt_state_e            st_q, st_d;
  logic [BITCNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]     sh_q, sh_d;
  logic                  oe_n_q, oe_n_d;
  logic                  first_q, first_d;
  logic                  nack_q, nack_d;
  logic                  start_hi_q, start_hi_d;

  logic                  cls_smp;
  strap_e                cls_code;
  logic [6:0]            dev_addr;
  logic                  ptr_ld, wr_en, rd_adv;
  logic [BYTE_W-1:0]     rd_data;

  i2c_strap_classify u_classify (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clear   (start_ev),
    .sample  (cls_smp),
    .strap_s (strap_s),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .code    (cls_code)
  );

  assign dev_addr = {ADDR_UPPER, 2'(cls_code)};

  i2c_strap_regs #(.DW(BYTE_W), .DEPTH(REG_DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ptr_ld  (ptr_ld),
    .wr_en   (wr_en),
    .rd_adv  (rd_adv),
    .wr_data (sh_q),
    .rd_data (rd_data)
  );

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    oe_n_d     = oe_n_q;
    first_d    = first_q;
    nack_d     = nack_q;
    start_hi_d = start_hi_q;
    cls_smp    = 1'b0;
    ptr_ld     = 1'b0;
    wr_en      = 1'b0;
    rd_adv     = 1'b0;

    if (scl_fall) start_hi_d = 1'b0;

    if (start_ev) begin
      st_d       = ST_ADDR;
      cnt_d      = '0;
      oe_n_d     = 1'b1;
      start_hi_d = 1'b1;
    end else if (stop_ev && !start_hi_q) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      oe_n_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR: begin
          if ((st_q == ST_ADDR) && (cnt_q < BIT_LAST) && (scl_rise || scl_fall))
            cls_smp = 1'b1;
          if (scl_rise && (cnt_q < BIT_LAST)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + BITCNT_W'(1);
          end else if (scl_rise && (cnt_q == BIT_LAST)) begin
            cnt_d = BIT_ACK;
          end else if (scl_fall && (cnt_q == BIT_LAST)) begin
            if (st_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == dev_addr) oe_n_d = 1'b0;
              else                              st_d   = ST_WAIT;
            end else begin
              oe_n_d  = 1'b0;
              ptr_ld  = first_q;
              wr_en   = ~first_q;
              first_d = 1'b0;
            end
          end else if (scl_fall && (cnt_q == BIT_ACK)) begin
            oe_n_d = 1'b1;
            cnt_d  = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[0]) begin
                st_d   = ST_RD;
                sh_d   = rd_data;
                oe_n_d = rd_data[BYTE_W-1];
              end else begin
                st_d    = ST_WR;
                first_d = 1'b1;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise && (cnt_q < BIT_LAST)) begin
            cnt_d = cnt_q + BITCNT_W'(1);
          end else if (scl_rise && (cnt_q == BIT_LAST)) begin
            cnt_d  = BIT_ACK;
            nack_d = sda_s;
          end else if (scl_fall && (cnt_q != '0) && (cnt_q < BIT_LAST)) begin
            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
            oe_n_d = sh_q[BYTE_W-2];
          end else if (scl_fall && (cnt_q == BIT_LAST)) begin
            oe_n_d = 1'b1;
            rd_adv = 1'b1;
          end else if (scl_fall && (cnt_q == BIT_ACK)) begin
            cnt_d = '0;
            if (nack_q) begin
              st_d   = ST_WAIT;
              oe_n_d = 1'b1;
            end else begin
              sh_d   = rd_data;
              oe_n_d = rd_data[BYTE_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      oe_n_q     <= 1'b1;
      first_q    <= 1'b0;
      nack_q     <= 1'b0;
      start_hi_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      oe_n_q     <= oe_n_d;
      first_q    <= first_d;
      nack_q     <= nack_d;
      start_hi_q <= start_hi_d;
    end
  end

  assign sda_oe_n = oe_n_q;

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk
  import i2c_strap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       start_hi,
  input tgt_state_e st,
  input logic       sda_oe_n
);

  // R12
  oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_n) |-> !$past(scl_s));

  // R2
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR));

  // R10
  early_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && start_hi && !start_ev) |=> (st == ST_ADDR));

  // R9
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_hi && !start_ev) |=> (st == ST_IDLE));

  // R5
  released_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) || (st == ST_WAIT)) |-> sda_oe_n);

endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .start_hi (start_hi_q),
  .st       (st_q),
  .sda_oe_n (sda_oe_n)
);

// File: tb/i2c_strap_target_bench.sv
`timescale 1ns/1ps
module i2c_strap_target_bench;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [1:0] strap_mode;
  logic strap_w;
  logic sda_oe_n;
  wire  sda_bus;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & sda_oe_n;

  always_comb begin
    case (strap_mode)
      2'd0:    strap_w = 1'b0;
      2'd1:    strap_w = 1'b1;
      2'd2:    strap_w = scl_m;
      default: strap_w = sda_bus;
    endcase
  end

  i2c_strap_target u_i2c_strap_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .strap_i  (strap_w),
    .sda_oe_n (sda_oe_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int viol  = 0;
  logic prev_oe = 1'b1;
  bit done = 1'b0;
  logic [7:0] mdl_mem [16];
  int mdl_ptr = 0;

  // R12 monitor: pull-down may only start while the bench holds the clock low
  always @(posedge clk) begin
    if (rst_n && prev_oe && !sda_oe_n && scl_m) viol <= viol + 1;
    prev_oe <= sda_oe_n;
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] dev7(input logic [1:0] m);
    return {5'b10011, m};
  endfunction

  task automatic put_bit(input logic b);
    scl_m = 1'b0; wq(Q);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(2*Q);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_bus;
    wq(Q);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq(Q);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus;
      wq(Q);
    end
    scl_m = 1'b0; wq(Q);
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
  endtask

  task automatic do_write(input logic [1:0] m, input logic [6:0] a7,
                          input logic [7:0] ptr, input int n);
    logic ak;
    logic hit;
    logic [7:0] d;
    hit = (a7 == dev7(m));
    strap_mode = m;
    bus_start();
    send_byte({a7, 1'b0}, ak);
    check(hit ? "R2 R3 R4 write address ack" : "R5 wrong address nack", int'(ak), int'(hit));
    send_byte(ptr, ak);
    check(hit ? "R6 pointer byte ack" : "R5 ignored after mismatch", int'(ak), int'(hit));
    if (hit) mdl_ptr = int'(ptr[3:0]);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ak);
      check(hit ? "R6 data byte ack" : "R5 ignored after mismatch", int'(ak), int'(hit));
      if (hit) begin
        mdl_mem[mdl_ptr] = d;
        mdl_ptr = (mdl_ptr + 1) % 16;
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [1:0] m, input logic [6:0] a7, input bit set_ptr,
                         input logic [7:0] ptr, input int n);
    logic ak;
    logic hit;
    logic [7:0] d;
    hit = (a7 == dev7(m));
    strap_mode = m;
    bus_start();
    if (set_ptr) begin
      send_byte({a7, 1'b0}, ak);
      check(hit ? "R4 write address ack" : "R5 wrong address nack", int'(ak), int'(hit));
      send_byte(ptr, ak);
      check(hit ? "R6 pointer byte ack" : "R5 ignored after mismatch", int'(ak), int'(hit));
      if (hit) mdl_ptr = int'(ptr[3:0]);
      bus_start();
    end
    send_byte({a7, 1'b1}, ak);
    check(hit ? (set_ptr ? "R11 R3 read address after repeated start" : "R3 R4 read address ack")
              : "R5 wrong read address nack", int'(ak), int'(hit));
    if (hit) begin
      for (int i = 0; i < n; i++) begin
        get_byte(i < n - 1, d);
        check("R7 read data", int'(d), int'(mdl_mem[mdl_ptr]));
        mdl_ptr = (mdl_ptr + 1) % 16;
      end
    end else begin
      get_byte(1'b0, d);
      check("R5 line released after mismatch", int'(d), 32'hFF);
    end
    bus_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    logic [1:0] m, wm;
    logic [6:0] a7;
    int kind, n;

    void'($urandom(32'd5107));
    for (int i = 0; i < 16; i++) mdl_mem[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap_mode = 2'd0;
    wq(6);
    rst_n = 1'b1;
    wq(6);
    // R1: released after reset, registers zero from pointer 0
    check("R1 reset release", int'(sda_oe_n), 1);
    do_read(2'd0, dev7(2'd0), 1'b0, 8'h00, 4);

    // R3 R6: each strap wiring with its own address
    for (int k = 0; k < 4; k++) begin
      do_write(2'(k), dev7(2'(k)), 8'(4 * k), 3);
      do_read(2'(k), dev7(2'(k)), 1'b1, 8'(4 * k), 3);
    end

    // R5: neighbouring codes are rejected for each wiring
    for (int k = 0; k < 4; k++) begin
      do_write(2'(k), dev7(2'(k + 1)), 8'h02, 1);
    end

    // R6 R11: pointer wrap 14,15,0,1 read back through repeated start
    do_write(2'd3, dev7(2'd3), 8'hFE, 4);
    do_read(2'd3, dev7(2'd3), 1'b1, 8'h0E, 4);

    // R8: not-acknowledge releases the line
    strap_mode = 2'd1;
    bus_start();
    send_byte({dev7(2'd1), 1'b1}, ak);
    check("R8 read address ack", int'(ak), 1);
    get_byte(1'b0, d);
    check("R8 last byte data", int'(d), int'(mdl_mem[mdl_ptr]));
    mdl_ptr = (mdl_ptr + 1) % 16;
    get_byte(1'b1, d);
    check("R8 released after nack", int'(d), 32'hFF);
    bus_stop();

    // R9: stop in mid byte, then a byte without start
    strap_mode = 2'd1;
    bus_start();
    send_byte({dev7(2'd1), 1'b0}, ak);
    check("R9 address ack", int'(ak), 1);
    send_byte(8'h05, ak);
    check("R9 pointer ack", int'(ak), 1);
    mdl_ptr = 5;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    send_byte({dev7(2'd1), 1'b0}, ak);
    check("R9 idle after stop no ack", int'(ak), 0);
    do_read(2'd1, dev7(2'd1), 1'b1, 8'h05, 2);

    // R10: stop inside the start's clock-high period is ignored
    strap_mode = 2'd2;
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    send_byte({dev7(2'd2), 1'b0}, ak);
    check("R10 address ack after ignored stop", int'(ak), 1);
    bus_stop();

    // random mix
    for (int t = 0; t < 30; t++) begin
      m = 2'($urandom % 4);
      kind = int'($urandom % 3);
      n = 1 + int'($urandom % 4);
      a7 = dev7(m);
      if (($urandom % 8) == 0) begin
        wm = 2'(m + 2'(1 + ($urandom % 3)));
        a7 = dev7(wm);
      end
      case (kind)
        0:       do_write(m, a7, 8'($urandom), n);
        1:       do_read(m, a7, 1'b0, 8'h00, n);
        default: do_read(m, a7, 1'b1, 8'($urandom), n);
      endcase
    end

    check("R12 pull-down only while clock low", viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule